// File: doc/BRIEF.md
# Full-Memory Write-Readback Tester

This block is a self-test sequencer. It sits in front of the request/acknowledge user port of a memory controller. After a start pulse it writes every word of the memory in ascending address order. Each write carries a value that is computed from the address, so the block never needs to store what it wrote. It then idles for a fixed number of cycles. After that it reads the whole memory back in the same order and recomputes the value each word should hold.

Any word that comes back different sets a sticky fail flag and increments a saturating mismatch counter. The sweep still runs to the last address. When it finishes, the block raises done, and it raises pass only if no word differed. A new start pulse in the finished or idle state runs the test again from a clean state. A synchronous reset returns the block to idle at any time.

Top module: `memsweep_tester`

## Requirements
- R1: After a synchronous reset the block is idle: req_valid, done, pass and fail are 0 and err_count is 0.
- R2: A start pulse while idle begins the write pass at address 0. Each acknowledged write moves to the next address (+1) until the all-ones address. The write data is the address zero-extended to the data width XORed with SEED, and inverted in full for odd addresses when INVERT_ODD is 1.
- R3: While req_valid is 1 and req_ack is 0, req_addr, req_write and req_wdata keep their values into the next cycle.
- R4: After the last write is acknowledged, req_valid stays 0 for exactly PAUSE_CYCLES cycles. The next request is then a read of address 0.
- R5: Reads (req_write = 0) visit addresses in ascending order from 0. Only one read is outstanding at a time: the next read request appears only after the read data of the previous one has been taken on rd_valid.
- R6: A read word that differs from the recomputed pattern sets fail from the following cycle, during the read pass. fail then stays 1 until a reset or an accepted start.
- R7: err_count grows by one for each differing word and saturates at its all-ones value. It is nonzero exactly when fail is 1.
- R8: done rises after the data of the last read is taken, and the block issues no requests while done is 1. pass is 1 only while done is 1 and fail is 0.
- R9: A start pulse during the write, pause or read pass is ignored: the running sweep neither restarts nor changes.
- R10: A start pulse while done is 1 clears done, fail and err_count in the next cycle and runs the full test again.
- R11: rd_valid pulses that arrive when no read is outstanding change neither fail nor err_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted while idle or done |
| req_valid | output | 1 | Request to the controller, held until req_ack |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | AW | Word address of the request |
| req_wdata | output | DW | Write data |
| req_ack | input | 1 | Controller accepts the current request |
| rd_valid | input | 1 | Read data is present on rd_data |
| rd_data | input | DW | Data returned by a read |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | At least one mismatch seen (sticky) |
| err_count | output | CW | Saturating number of mismatching words |

## Verification
The bench runs the sweep against a clean memory model with zero-wait responses, which shows the address order, the pattern, the pause length and the pass result without any stall. It runs the sweep again with an acknowledge delay and a read-data delay, which separates a request that is held until accepted from one that moves on early, and shows that a second read is not issued too soon. Next it corrupts one word and then all words, to tell a single sticky fail from a counter that has to saturate. Finally, stray read-valid pulses during the pause, a start pulse in the middle of the read pass, a restart after a failing run and a reset during the write pass check that each is ignored or clears the state as R9 to R11 and R1 require.

// File: rtl/memsweep_pkg.sv
package memsweep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_PAUSE = 3'd2,
      ST_READ  = 3'd3,
      ST_RWAIT = 3'd4,
      ST_DONE  = 3'd5
   } sweep_state_t;
endpackage

// File: rtl/memsweep_pattern.sv
module memsweep_pattern #(
   parameter int          AW         = 22,
   parameter int          DW         = 32,
   parameter logic [DW-1:0] SEED     = '0,
   parameter bit          INVERT_ODD = 1'b0
) (
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] data
);
   logic [DW-1:0] ext;

   // fit the address into the data width
   generate
      if (DW > AW) begin : g_pad
         assign ext = {{(DW-AW){1'b0}}, addr};
      end else if (DW == AW) begin : g_same
         assign ext = addr;
      end else begin : g_trim
         assign ext = addr[DW-1:0];
      end
   endgenerate

   generate
      if (INVERT_ODD) begin : g_alt
         assign data = addr[0] ? ~(ext ^ SEED) : (ext ^ SEED);
      end else begin : g_plain
         assign data = ext ^ SEED;
      end
   endgenerate
endmodule

// File: rtl/memsweep_addr_ctr.sv
module memsweep_addr_ctr #(
   parameter int AW = 22
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] addr,
   output logic          last
);
   localparam logic [AW-1:0] TOP = {AW{1'b1}};

   always_ff @(posedge clk) begin
      if (clr)      addr <= '0;
      else if (inc) addr <= addr + 1'b1;
   end

   assign last = (addr == TOP);
endmodule

// File: rtl/memsweep_pause_timer.sv
module memsweep_pause_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic en,
   output logic expire
);
   localparam int TW = $clog2(CYCLES + 1);
   localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!en) cnt <= '0;
      else     cnt <= cnt + 1'b1;
   end

   assign expire = en && (cnt == LAST);
endmodule

// File: rtl/memsweep_err_tracker.sv
module memsweep_err_tracker #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          hit,
   output logic          fail,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   always_ff @(posedge clk) begin
      if (clr) begin
         fail  <= 1'b0;
         count <= '0;
      end else if (hit) begin
         fail <= 1'b1;
         if (count != CMAX) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/memsweep_tester.sv
module memsweep_tester
   import memsweep_pkg::*;
#(
   parameter int            AW           = 22,
   parameter int            DW           = 32,
   parameter int            CW           = 8,
   parameter int            PAUSE_CYCLES = 1000,
   parameter logic [DW-1:0] SEED         = 32'h5A3C_96E1,
   parameter bit            INVERT_ODD   = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   output logic          req_valid,
   output logic          req_write,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_wdata,
   input  logic          req_ack,
   input  logic          rd_valid,
   input  logic [DW-1:0] rd_data,
   output logic          done,
   output logic          pass,
   output logic          fail,
   output logic [CW-1:0] err_count
);
   generate
      if (AW < 1)           begin : g_bad_aw    $error("AW must be at least 1"); end
      if (DW < 1)           begin : g_bad_dw    $error("DW must be at least 1"); end
      if (CW < 1)           begin : g_bad_cw    $error("CW must be at least 1"); end
      if (PAUSE_CYCLES < 1) begin : g_bad_pause $error("PAUSE_CYCLES must be at least 1"); end
   endgenerate

   sweep_state_t  state, state_nx;
   logic [AW-1:0] addr;
   logic          addr_last;
   logic [DW-1:0] pat;
   logic          pause_done;
   logic          start_ok;
   logic          wr_step, rd_take, mismatch;
   logic          addr_clr, addr_inc;

   assign start_ok = start && (state == ST_IDLE || state == ST_DONE);
   assign wr_step  = (state == ST_WRITE) && req_ack;
   assign rd_take  = (state == ST_RWAIT) && rd_valid;
   assign mismatch = rd_take && (rd_data != pat);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start_ok) state_nx = ST_WRITE;
         ST_WRITE: if (wr_step && addr_last) state_nx = ST_PAUSE;
         ST_PAUSE: if (pause_done) state_nx = ST_READ;
         ST_READ:  if (req_ack) state_nx = ST_RWAIT;
         ST_RWAIT: if (rd_take) state_nx = addr_last ? ST_DONE : ST_READ;
         ST_DONE:  if (start_ok) state_nx = ST_WRITE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= state_nx;
   end

   // address restarts at 0 for each pass
   assign addr_clr = rst || start_ok || (wr_step && addr_last);
   assign addr_inc = (wr_step || rd_take) && !addr_last;

   memsweep_addr_ctr #(.AW(AW)) u_addr (
      .clk  (clk),
      .clr  (addr_clr),
      .inc  (addr_inc),
      .addr (addr),
      .last (addr_last)
   );

   memsweep_pattern #(
      .AW(AW), .DW(DW), .SEED(SEED), .INVERT_ODD(INVERT_ODD)
   ) u_pat (
      .addr (addr),
      .data (pat)
   );

   memsweep_pause_timer #(.CYCLES(PAUSE_CYCLES)) u_pause (
      .clk    (clk),
      .en     (state == ST_PAUSE),
      .expire (pause_done)
   );

   memsweep_err_tracker #(.CW(CW)) u_err (
      .clk   (clk),
      .clr   (rst || start_ok),
      .hit   (mismatch),
      .fail  (fail),
      .count (err_count)
   );

   assign req_valid = (state == ST_WRITE) || (state == ST_READ);
   assign req_write = (state == ST_WRITE);
   assign req_addr  = addr;
   assign req_wdata = pat;
   assign done      = (state == ST_DONE);
   assign pass      = done && !fail;
endmodule

// File: rtl/memsweep_tester_chk.sv
module memsweep_tester_chk #(
   parameter int AW = 22,
   parameter int DW = 32,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          req_valid,
   input logic          req_write,
   input logic [AW-1:0] req_addr,
   input logic [DW-1:0] req_wdata,
   input logic          req_ack,
   input logic          done,
   input logic          pass,
   input logic          fail,
   input logic [CW-1:0] err_count
);
   p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!req_valid && !done && !pass && !fail && err_count == '0));

   p_write_step_r2: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ack && req_write && !(&req_addr)) |=>
         (req_valid && req_write && req_addr == AW'($past(req_addr) + 1'b1)));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_ack) |=>
         (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

   p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (fail && !start) |=> fail);

   p_count_tracks_fail_r7: assert property (@(posedge clk) disable iff (rst)
      fail == (err_count != '0));

   p_pass_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
      pass |-> (done && !fail));

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      done |-> !req_valid);
endmodule

bind memsweep_tester memsweep_tester_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .req_ack   (req_ack),
   .done      (done),
   .pass      (pass),
   .fail      (fail),
   .err_count (err_count)
);

// File: tb/memsweep_tester_tb_top.sv
module memsweep_tester_tb_top;
   localparam int            AW    = 3;
   localparam int            DW    = 16;
   localparam int            CW    = 3;
   localparam int            PAUSE = 5;
   localparam int            WORDS = 1 << AW;
   localparam logic [DW-1:0] SEED  = 16'hA5C3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          req_valid, req_write, done, pass, fail;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          req_ack = 1'b0;
   logic          rd_valid = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic [CW-1:0] err_count;

   always #5 clk = ~clk;

   memsweep_tester #(
      .AW(AW), .DW(DW), .CW(CW), .PAUSE_CYCLES(PAUSE),
      .SEED(SEED), .INVERT_ODD(1'b1)
   ) dut_i (
      .clk(clk), .rst(rst), .start(start),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .done(done), .pass(pass), .fail(fail), .err_count(err_count)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // memory model state
   logic [DW-1:0] mem [WORDS];
   int  ack_lat = 0, rd_lat = 0;
   logic [WORDS-1:0] corrupt = '0;
   bit  stray_en = 0;
   int  nwr, nri, nrd, gap, wc, rdc, pa;
   bit  pend, prev_valid, prev_write, prev_acked, acked;
   logic [AW-1:0] prev_addr;
   logic [DW-1:0] prev_wdata;
   int  order_err, hold_err, outst_err;
   bit  early_fail;

   function automatic logic [DW-1:0] exp_pat(int a);
      logic [DW-1:0] v;
      v = DW'(a) ^ SEED;
      if (a % 2 == 1) v = ~v;
      return v;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      nwr = 0; nri = 0; nrd = 0; gap = 0; wc = 0; rdc = 0; pa = 0;
      pend = 0; prev_valid = 0; prev_acked = 0;
      order_err = 0; hold_err = 0; outst_err = 0; early_fail = 0;
   endtask

   // responder: drives on negedge, the design samples on posedge
   initial begin
      model_clear();
      forever begin
         @(negedge clk);
         if (rst) begin
            req_ack = 0; rd_valid = 0; pend = 0; prev_valid = 0;
         end else begin
            if (pend && req_valid) outst_err++;
            if (prev_valid && !prev_acked && req_valid &&
                (req_addr != prev_addr || req_wdata != prev_wdata || req_write != prev_write))
               hold_err++;
            if (fail && !done) early_fail = 1;
            req_ack = 0; rd_valid = 0; acked = 0;
            if (pend) begin
               if (rdc >= rd_lat) begin
                  rd_valid = 1;
                  rd_data  = mem[pa] ^ (corrupt[pa] ? 16'h0100 : 16'h0000);
                  pend = 0; nrd++;
               end else rdc++;
            end else if (stray_en && nwr == WORDS && nri == 0 && !req_valid) begin
               rd_valid = 1; rd_data = 16'hDEAD;
            end
            if (req_valid && !pend) begin
               if (wc >= ack_lat) begin
                  req_ack = 1; acked = 1; wc = 0;
                  if (req_write) begin
                     if (int'(req_addr) != nwr || req_wdata != exp_pat(nwr)) order_err++;
                     mem[req_addr] = req_wdata; nwr++;
                  end else begin
                     if (int'(req_addr) != nri || nwr != WORDS) order_err++;
                     pend = 1; pa = int'(req_addr); rdc = 0; nri++;
                  end
               end else wc++;
            end
            if (nwr == WORDS && nri == 0 && !req_valid) gap++;
            prev_valid = req_valid; prev_write = req_write;
            prev_addr = req_addr; prev_wdata = req_wdata; prev_acked = acked;
         end
      end
   end

   task automatic finish_report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_report();
   end

   task automatic pulse_start();
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
   endtask

   task automatic wait_done(string req);
      int t = 0;
      while (!done && t < 3000) begin @(negedge clk); t++; end
      chk(done == 1, req, done, 1);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1;
      @(negedge clk); @(negedge clk); rst = 0;
      @(negedge clk);
   endtask

   task automatic run(int al, int rl, logic [WORDS-1:0] cm, bit st);
      ack_lat = al; rd_lat = rl; corrupt = cm; stray_en = st;
      model_clear();
      pulse_start();
      wait_done("R8 done after sweep");
   endtask

   task automatic t_reset();
      do_reset();
      chk(!req_valid && !done && !pass && !fail, "R1 idle outputs",
          {req_valid, done, pass, fail}, 0);
      chk(err_count == 0, "R1 count cleared", err_count, 0);
   endtask

   task automatic t_clean_fast();
      run(0, 0, '0, 0);
      chk(nwr == WORDS && order_err == 0, "R2 write order and pattern", order_err, 0);
      chk(gap == PAUSE, "R4 pause length", gap, PAUSE);
      chk(nrd == WORDS && outst_err == 0, "R5 read count, one outstanding", nrd, WORDS);
      chk(pass && !fail && err_count == 0, "R8 pass on clean memory", pass, 1);
   endtask

   task automatic t_slow();
      run(2, 3, '0, 0);
      chk(hold_err == 0, "R3 request held while waiting", hold_err, 0);
      chk(outst_err == 0, "R5 no read issued before data", outst_err, 0);
      chk(order_err == 0 && nrd == WORDS, "R5 read order under delay", order_err, 0);
      chk(gap == PAUSE, "R4 pause length with delays", gap, PAUSE);
      chk(pass == 1, "R8 pass with delays", pass, 1);
   endtask

   task automatic t_one_bad();
      run(1, 1, 8'b0000_0100, 0);
      chk(fail == 1 && pass == 0, "R6 fail on one bad word", fail, 1);
      chk(early_fail == 1, "R6 fail shown before done", early_fail, 1);
      chk(nrd == WORDS, "R6 sweep runs to the end", nrd, WORDS);
      chk(err_count == 1, "R7 count one mismatch", err_count, 1);
   endtask

   task automatic t_restart();
      pulse_start();
      chk(!done && !fail && err_count == 0, "R10 restart clears indicators",
          {done, fail}, 0);
      model_clear();
      ack_lat = 0; rd_lat = 0; corrupt = '0;
      wait_done("R10 restarted run completes");
      chk(nwr == WORDS && pass == 1, "R10 rerun passes", nwr, WORDS);
   endtask

   task automatic t_all_bad();
      run(0, 0, '1, 0);
      chk(err_count == 3'd7, "R7 count saturates", err_count, 7);
      chk(fail == 1 && pass == 0, "R6 fail with all bad", fail, 1);
   endtask

   task automatic t_stray();
      do_reset();
      run(0, 1, '0, 1);
      chk(fail == 0 && err_count == 0 && pass == 1, "R11 stray rd_valid ignored",
          err_count, 0);
   endtask

   task automatic t_start_busy();
      int t = 0;
      ack_lat = 1; rd_lat = 1; corrupt = '0; stray_en = 0;
      model_clear();
      pulse_start();
      while (nri < 3 && t < 3000) begin @(negedge clk); t++; end
      pulse_start();
      wait_done("R9 done after ignored start");
      chk(nwr == WORDS && order_err == 0, "R9 no restart of writes", nwr, WORDS);
      chk(nrd == WORDS && pass == 1, "R9 read pass unchanged", nrd, WORDS);
   endtask

   task automatic t_reset_mid();
      ack_lat = 0; rd_lat = 0; corrupt = '0;
      model_clear();
      pulse_start();
      repeat (3) @(negedge clk);
      do_reset();
      chk(!req_valid && !done && !fail && err_count == 0, "R1 reset mid-sweep",
          req_valid, 0);
   endtask

   initial begin
      t_reset();
      t_clean_fast();
      t_slow();
      t_one_bad();
      t_restart();
      t_all_bad();
      t_stray();
      t_start_busy();
      t_reset_mid();
      finish_report();
   end
endmodule